// File: doc/BRIEF.md
# Temperature-Indexed Table Address Generator

This block converts a periodic digital temperature reading into an index into a 72-entry settings table. It then loads the entry at that index into two 8-bit channel setting registers. Each index covers a 2 °C band, and the lowest band starts at −40 °C. Every step between neighbouring bands carries 1 °C of hysteresis, so a reading that sits on a band edge does not make the index chatter. The table is outside the block. It is read through a port with combinational data return, addressed by channel and index.

Two enables set the operating mode. With conversion disabled, incoming readings are ignored and a host writes the channel settings directly (manual mode). With index update disabled, readings still cause the settings to be reloaded, but the index stays put, and a host may write the index itself to look at any table row (test mode). A sticky flag goes high each time both channel settings have been reloaded. A host can clear it and then poll for it to return.

Top module: `thermal_index_gen`

## Requirements
- R1: The temperature is bits [15:3] of `temp_word`, read as a signed 13-bit value in 1/16 °C. After reset, the first accepted reading sets the index directly to floor((T+40)/2), clamped to 0..71 (FAF0h, −10.125 °C, gives 0Eh; 0C88h gives 20h).
- R2: Once seeded, the index rises to the largest k for which T ≥ −40 + 2k + 0.5 °C, when that k is above the current index (from 20h, 0D38h holds and 0D40h gives 21h).
- R3: Once seeded, the index falls to the smallest k for which T < −40 + 2(k+1) − 0.5 °C, when that k is below the current index. Otherwise the index holds (from 21h, 0CC0h holds and 0CB8h gives 20h).
- R4: The index never leaves 00h..47h. Readings below −40 °C give 00h, readings above the last band give 47h, and a host index write above 47h loads 47h.
- R5: A reading is accepted only when `temp_valid` is high, `bus_busy` is low and no table load is in progress. A refused reading changes neither the index, the settings nor the flag.
- R6: An accepted reading or host index write starts a table load. In the cycle after acceptance the table is read with `tbl_ch`=0 and the channel 0 setting is written. In the next cycle it is read with `tbl_ch`=1 and the channel 1 setting is written. Both reads use the current index.
- R7: `upd_flag` goes to 1 in the cycle in which channel 1 is loaded. `flag_clr` clears it, and if a set and a clear fall in the same cycle, the set wins.
- R8: With `conv_en` low, readings are ignored. Bit c of `host_set_wr` writes `host_set_data` into channel c's setting. With `conv_en` high, these writes have no effect.
- R9: With `idx_upd_en` low, an accepted reading leaves the index unchanged but still reloads both settings and sets the flag, and `host_idx_wr` loads the index and starts a table load. With `idx_upd_en` high, host index writes have no effect.
- R10: Reset clears the index, both settings and the flag, and marks the index as not yet seeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_word | input | 16 | Left-justified signed temperature, 1/16 °C per LSB of bits [15:3] |
| temp_valid | input | 1 | One-cycle strobe marking a new reading |
| bus_busy | input | 1 | High while a serial transaction is in progress |
| conv_en | input | 1 | Automatic conversion enable |
| idx_upd_en | input | 1 | Temperature-driven index update enable |
| flag_clr | input | 1 | Host clear of the update flag |
| host_idx_wr | input | 1 | Host index write strobe |
| host_idx | input | 7 | Host index value |
| host_set_wr | input | 2 | Per-channel host setting write strobes |
| host_set_data | input | 8 | Host setting value |
| tbl_rd_en | output | 1 | Table read active |
| tbl_ch | output | 1 | Table channel being read |
| tbl_addr | output | 7 | Table row being read |
| tbl_data | input | 8 | Table data for the current read |
| cur_idx | output | 7 | Current table index |
| ch0_setting | output | 8 | Channel 0 setting |
| ch1_setting | output | 8 | Channel 1 setting |
| upd_flag | output | 1 | Sticky update-complete flag |

## Verification
The hardest situation to reach is a hysteresis decision that depends on history. The same reading must give different indices depending on the band the index came from, for example −10.125 °C landing on 0Fh when falling from the top clamp but on 0Eh as a first reading after reset. The stimulus walks an ordered sequence of readings placed 1/16 °C on either side of the rising and falling thresholds, then resets and replays one of those readings. A reading sent while a load is still running, and a flag clear timed into the exact cycle of a flag set, are produced by pulsing the inputs at counted cycles after acceptance.

// File: rtl/tig_pkg.sv
package tig_pkg;
  localparam int WORD_W    = 16;
  localparam int TEMP_W    = 13;
  localparam int IDX_W     = 7;
  localparam int SET_W     = 8;
  localparam int ENTRIES   = 72;
  localparam int CHANNELS  = 2;
  localparam int FRAC_Q    = 16;            // LSBs per degree
  localparam int STEP_Q    = 2 * FRAC_Q;    // band width
  localparam int HYST_Q    = FRAC_Q / 2;    // half of the hysteresis on each side
  localparam int BASE_Q    = -40 * FRAC_Q;  // lower edge of band 0
  localparam int LAST_IDX  = ENTRIES - 1;

  // Band index of (t + bias), clamped to the table.
  function automatic logic [IDX_W-1:0] band_index(input logic signed [TEMP_W-1:0] t,
                                                  input int bias);
    int q;
    q = int'(t) + bias - BASE_Q;
    if (q < 0) return '0;
    q = q / STEP_Q;
    if (q > LAST_IDX) q = LAST_IDX;
    return IDX_W'(q);
  endfunction

  function automatic logic [IDX_W-1:0] clamp_host(input logic [IDX_W-1:0] v);
    return (int'(v) > LAST_IDX) ? IDX_W'(LAST_IDX) : v;
  endfunction
endpackage

// File: rtl/tig_index_calc.sv
module tig_index_calc
  import tig_pkg::*;
(
  input  logic signed [TEMP_W-1:0] temp_q,
  input  logic [IDX_W-1:0]         cur_idx,
  input  logic                     seeded,
  output logic [IDX_W-1:0]         next_idx
);
  logic [IDX_W-1:0] direct_idx, up_idx, down_idx;

  always_comb begin
    direct_idx = band_index(temp_q, 0);
    up_idx     = band_index(temp_q, -HYST_Q);
    down_idx   = band_index(temp_q, HYST_Q);
    if (!seeded)                next_idx = direct_idx;
    else if (up_idx > cur_idx)  next_idx = up_idx;
    else if (down_idx < cur_idx) next_idx = down_idx;
    else                        next_idx = cur_idx;
  end
endmodule

// File: rtl/tig_load_seq.sv
module tig_load_seq #(
  parameter int CHANNELS = 2,
  localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic [CH_W-1:0]     ch_sel,
  output logic [CHANNELS-1:0] ld_vec,
  output logic                done
);
  logic            active;
  logic [CH_W-1:0] ch_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ch_cnt <= '0;
    end else if (start) begin
      active <= 1'b1;
      ch_cnt <= '0;
    end else if (active) begin
      if (int'(ch_cnt) == CHANNELS - 1) active <= 1'b0;
      else ch_cnt <= ch_cnt + 1'b1;
    end
  end

  assign busy   = active;
  assign ch_sel = ch_cnt;
  assign done   = active && (int'(ch_cnt) == CHANNELS - 1);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ld
    assign ld_vec[c] = active && (int'(ch_cnt) == c);
  end
endmodule

// File: rtl/tig_setting_reg.sv
module tig_setting_reg #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [SET_W-1:0] load_data,
  input  logic             host_we,
  input  logic [SET_W-1:0] host_data,
  output logic [SET_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (load_we) q <= load_data;
    else if (host_we) q <= host_data;
  end
endmodule

// File: rtl/thermal_index_gen.sv
module thermal_index_gen
  import tig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] temp_word,
  input  logic              temp_valid,
  input  logic              bus_busy,
  input  logic              conv_en,
  input  logic              idx_upd_en,
  input  logic              flag_clr,
  input  logic              host_idx_wr,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [CHANNELS-1:0] host_set_wr,
  input  logic [SET_W-1:0]  host_set_data,
  output logic              tbl_rd_en,
  output logic              tbl_ch,
  output logic [IDX_W-1:0]  tbl_addr,
  input  logic [SET_W-1:0]  tbl_data,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [SET_W-1:0]  ch0_setting,
  output logic [SET_W-1:0]  ch1_setting,
  output logic              upd_flag
);
  localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  logic signed [TEMP_W-1:0] temp_q;
  logic [IDX_W-1:0]         next_idx;
  logic                     seeded;
  logic                     seq_busy, seq_done;
  logic [CH_W-1:0]          seq_ch;
  logic [CHANNELS-1:0]      ld_vec;
  logic                     host_idx_ok, take_sample, seq_start;
  logic [SET_W-1:0]         set_q [CHANNELS];

  assign temp_q      = $signed(temp_word[WORD_W-1 -: TEMP_W]);
  assign host_idx_ok = host_idx_wr && !idx_upd_en;
  assign take_sample = temp_valid && conv_en && !bus_busy && !seq_busy && !host_idx_ok;
  assign seq_start   = host_idx_ok || take_sample;

  tig_index_calc u_calc (
    .temp_q   (temp_q),
    .cur_idx  (cur_idx),
    .seeded   (seeded),
    .next_idx (next_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx <= '0;
      seeded  <= 1'b0;
    end else if (host_idx_ok) begin
      cur_idx <= clamp_host(host_idx);
    end else if (take_sample && idx_upd_en) begin
      cur_idx <= next_idx;
      seeded  <= 1'b1;
    end
  end

  tig_load_seq #(.CHANNELS(CHANNELS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (seq_start),
    .busy   (seq_busy),
    .ch_sel (seq_ch),
    .ld_vec (ld_vec),
    .done   (seq_done)
  );

  assign tbl_rd_en = seq_busy;
  assign tbl_ch    = seq_ch[0];
  assign tbl_addr  = cur_idx;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    tig_setting_reg #(.SET_W(SET_W)) u_set (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_we   (ld_vec[c]),
      .load_data (tbl_data),
      .host_we   (host_set_wr[c] && !conv_en),
      .host_data (host_set_data),
      .q         (set_q[c])
    );
  end

  assign ch0_setting = set_q[0];
  assign ch1_setting = set_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n)        upd_flag <= 1'b0;
    else if (seq_done) upd_flag <= 1'b1;
    else if (flag_clr) upd_flag <= 1'b0;
  end
endmodule

// File: rtl/tig_checker.sv
module tig_checker
  import tig_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_busy,
  input logic             conv_en,
  input logic             idx_upd_en,
  input logic             host_idx_wr,
  input logic [IDX_W-1:0] cur_idx,
  input logic             upd_flag,
  input logic             take_sample,
  input logic [1:0]       ld_vec
);
  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_idx) <= LAST_IDX);  // R4
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !take_sample);  // R5
  AST_NO_SAMPLE_MID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take_sample |-> (ld_vec == 2'b00));  // R5
  AST_CH1_AFTER_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vec[1] |-> $past(ld_vec[0]));  // R6
  AST_FLAG_RISE_ON_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_flag) |-> $past(ld_vec[1]));  // R7
  AST_CONV_OFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |-> !take_sample);  // R8
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_upd_en && !host_idx_wr) |=> $stable(cur_idx));  // R9
endmodule

bind thermal_index_gen tig_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_busy    (bus_busy),
  .conv_en     (conv_en),
  .idx_upd_en  (idx_upd_en),
  .host_idx_wr (host_idx_wr),
  .cur_idx     (cur_idx),
  .upd_flag    (upd_flag),
  .take_sample (take_sample),
  .ld_vec      (ld_vec)
);

// File: tb/thermal_index_gen_bench.sv
module thermal_index_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] temp_word = '0;
  logic        temp_valid = 1'b0, bus_busy = 1'b0, conv_en = 1'b1, idx_upd_en = 1'b1;
  logic        flag_clr = 1'b0, host_idx_wr = 1'b0;
  logic [6:0]  host_idx = '0;
  logic [1:0]  host_set_wr = '0;
  logic [7:0]  host_set_data = '0;
  logic        tbl_rd_en, tbl_ch;
  logic [6:0]  tbl_addr, cur_idx;
  logic [7:0]  tbl_data, ch0_setting, ch1_setting;
  logic        upd_flag;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] tbl_model(input logic ch, input logic [6:0] a);
    return ch ? (8'hA5 ^ {a, 1'b0}) : 8'(int'(a) * 3 + 1);
  endfunction

  assign tbl_data = tbl_model(tbl_ch, tbl_addr);

  thermal_index_gen u_thermal_index_gen (
    .clk(clk), .rst_n(rst_n), .temp_word(temp_word), .temp_valid(temp_valid),
    .bus_busy(bus_busy), .conv_en(conv_en), .idx_upd_en(idx_upd_en),
    .flag_clr(flag_clr), .host_idx_wr(host_idx_wr), .host_idx(host_idx),
    .host_set_wr(host_set_wr), .host_set_data(host_set_data),
    .tbl_rd_en(tbl_rd_en), .tbl_ch(tbl_ch), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .cur_idx(cur_idx), .ch0_setting(ch0_setting), .ch1_setting(ch1_setting),
    .upd_flag(upd_flag)
  );

  // {tag code, temperature word, expected index}; walked in order
  localparam logic [24:0] VECS [0:10] = '{
    {2'd0, 16'h0C88, 7'd32}, {2'd1, 16'h0D38, 7'd32}, {2'd1, 16'h0D40, 7'd33},
    {2'd2, 16'h0CC0, 7'd33}, {2'd2, 16'h0CB8, 7'd32}, {2'd1, 16'h2F80, 7'd67},
    {2'd3, 16'h3C00, 7'd71}, {2'd2, 16'hFAF0, 7'd15}, {2'd3, 16'hE200, 7'd0},
    {2'd3, 16'hEC00, 7'd0},  {2'd1, 16'hED40, 7'd1}
  };

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_temp(input logic [15:0] w);
    @(negedge clk) begin temp_word = w; temp_valid = 1'b1; end
    @(negedge clk) temp_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_idx(input logic [6:0] v);
    @(negedge clk) begin host_idx = v; host_idx_wr = 1'b1; end
    @(negedge clk) host_idx_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_set(input int ch, input logic [7:0] v);
    @(negedge clk) begin host_set_data = v; host_set_wr = 2'b01 << ch; end
    @(negedge clk) host_set_wr = '0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic chk_row(input string req, input logic [6:0] idx);
    chk(req, cur_idx, idx);
    chk(req, ch0_setting, tbl_model(1'b0, idx));
    chk(req, ch1_setting, tbl_model(1'b1, idx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R10", cur_idx, 0);
    chk("R10", ch0_setting, 0);
    chk("R10", ch1_setting, 0);
    chk("R10", upd_flag, 0);

    for (int i = 0; i < 11; i++) begin
      send_temp(VECS[i][22:7]);
      chk_row(tag_of(VECS[i][24:23]), VECS[i][6:0]);
      chk("R7", upd_flag, 1);
    end

    // R7: host clear, then same-cycle set and clear
    pulse_clr();
    @(negedge clk);
    chk("R7", upd_flag, 0);
    @(negedge clk) begin temp_word = 16'h0C88; temp_valid = 1'b1; end
    @(negedge clk) temp_valid = 1'b0;
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk);
    chk("R7", upd_flag, 1);
    chk_row("R6", 7'd32);

    // R5: second reading during load is dropped
    @(negedge clk) begin temp_word = 16'hED40; temp_valid = 1'b1; end
    @(negedge clk) temp_word = 16'h2F80;
    @(negedge clk) temp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk_row("R5", 7'd1);
    send_temp(16'h0C88);
    chk_row("R2", 7'd32);

    // R5: busy bus refuses readings
    pulse_clr();
    bus_busy = 1'b1;
    send_temp(16'h2F80);
    chk("R5", cur_idx, 32);
    chk("R5", upd_flag, 0);
    bus_busy = 1'b0;

    // R8: manual mode
    conv_en = 1'b0;
    send_temp(16'h3C00);
    chk("R8", cur_idx, 32);
    chk("R8", upd_flag, 0);
    write_set(0, 8'h5A);
    write_set(1, 8'hC3);
    @(negedge clk);
    chk("R8", ch0_setting, 8'h5A);
    chk("R8", ch1_setting, 8'hC3);
    conv_en = 1'b1;
    write_set(0, 8'h11);
    @(negedge clk);
    chk("R8", ch0_setting, 8'h5A);

    // R9: test mode
    idx_upd_en = 1'b0;
    send_temp(16'h3C00);
    chk_row("R9", 7'd32);
    chk("R9", upd_flag, 1);
    write_idx(7'h50);
    chk_row("R4", 7'd71);
    write_idx(7'd5);
    chk_row("R9", 7'd5);
    idx_upd_en = 1'b1;
    write_idx(7'd9);
    chk_row("R9", 7'd5);

    // R1: first reading after reset is direct
    do_reset();
    send_temp(16'hFAF0);
    chk_row("R1", 7'd14);
    send_temp(16'hFAF0);
    chk("R3", cur_idx, 14);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule